// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Engine

This block models the write path of a byte-wide nonvolatile memory behind an asynchronous-style parallel bus. Three active-low strobes (chip select, output enable, write enable) and the address and data lines are sampled by the system clock. A write load begins when chip select and write enable are both low with output enable high. The address is taken in the cycle that load begins, and the data byte in the cycle it ends. Loads are gathered into a 128-byte page latch. All loads after the first must target the same page as the first load.

Each accepted load re-opens a byte-load window of `WIN_CYC` clock cycles. Once that window lapses with no load in progress, a self-timed programming cycle of `PROG_CYC` clocks copies the latched bytes into the internal array. During that cycle every read returns a status byte instead of array data, so software can poll until the write completes. The block has three states. `ST_IDLE` waits for a first load. `ST_LOAD` holds the page window open. `ST_PROG` runs the programming cycle. The transitions are: first-load (`ST_IDLE` to `ST_LOAD`), window-renew (`ST_LOAD` to itself on a same-page load), window-lapse (`ST_LOAD` to `ST_PROG`) and program-done (`ST_PROG` to `ST_IDLE`).

Top module: `pwe_engine`

## Requirements
- R1: `dq_oe` is 1 exactly in those cycles where `ce_n` and `oe_n` are both low; otherwise the data port is released (`dq_oe`=0).
- R2: A load starts on the first clock edge at which `ce_n`=0, `we_n`=0, `oe_n`=1 and `wr_inhibit`=0 all hold, which is the later of the two falling strobes. The address is taken at that edge. The load ends on the first edge at which that condition no longer holds, which is the earlier rising strobe, and `dq_in` is taken at that edge.
- R3: The page is `addr[ADDR_W-1:7]`, and the byte offset is `addr[6:0]`. A load whose page differs from the first load's page is discarded and does not re-open the window.
- R4: Programming starts at the first edge at which at least `WIN_CYC` cycles have passed since the last accepted load start and no load is being asserted. From `ST_IDLE` the block never enters programming directly.
- R5: A new same-page load inside the window re-opens it, with no limit on the total load time.
- R6: While programming, any read returns the last loaded byte with bit 7 inverted and bits 5..0 unchanged.
- R7: While programming, bit 6 of a read starts at 0 and flips after each completed read (`ce_n` or `oe_n` rising). Outside programming the toggle stays 0.
- R8: Programming lasts exactly `PROG_CYC` cycles and never more than `PROG_MAX_CYC`. After it, reads return the new array contents.
- R9: Write strobes during programming are ignored, and the array is left unchanged.
- R10: A strobe pattern with `oe_n` low, or any pattern while `wr_inhibit` is high, changes nothing.
- R11: After reset the block is idle and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_inhibit | input | 1 | Low-supply write block, active high |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data or busy status |
| dq_oe | output | 1 | Drive enable for the data port |

## Verification
The hardest case to reach is the exact edge on which the window lapses while a read is held open. A late or early start of programming shows up only as a one-cycle change from array data to status. The stimulus therefore holds a read open across the whole window and compares every cycle against a behavioural model. It also renews the window many times over a span far longer than `WIN_CYC`, and it places an off-page load inside an open window to show that this load does not delay the lapse.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwe_state_e;
endpackage

// File: rtl/pwe_strobe_decode.sv
module pwe_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic wr_inhibit,
    output logic wr_active,
    output logic wr_start,
    output logic wr_end,
    output logic rd_active,
    output logic rd_end
);
    logic wr_q;
    logic rd_q;

    assign wr_active = ~ce_n & ~we_n & oe_n & ~wr_inhibit;
    assign rd_active = ~ce_n & ~oe_n;
    assign wr_start  = wr_active & ~wr_q;
    assign wr_end    = wr_q & ~wr_active;
    assign rd_end    = rd_q & ~rd_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_active;
            rd_q <= rd_active;
        end
    end
endmodule

// File: rtl/pwe_ctrl.sv
module pwe_ctrl
    import pwe_pkg::*;
#(
    parameter int WIN_CYC      = 10000,
    parameter int PROG_CYC     = 300000,
    parameter int PROG_MAX_CYC = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_start,
    input  logic       wr_end,
    input  logic       wr_active,
    input  logic       rd_end,
    input  logic       page_match,
    input  logic       wr_inhibit,
    output pwe_state_e state,
    output logic       take_first,
    output logic       take_load,
    output logic       capture,
    output logic       commit,
    output logic       busy,
    output logic       toggle
);
    localparam int WCW = $clog2(WIN_CYC + 1);
    localparam int PCW = $clog2(PROG_CYC + 1);
    localparam int BCW = $clog2(PROG_MAX_CYC + 2);
    localparam logic [WCW-1:0] WIN_LAST  = WCW'(WIN_CYC - 1);
    localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYC - 1);
    localparam logic [BCW-1:0] BUSY_CAP  = BCW'(PROG_MAX_CYC + 1);

    pwe_state_e nxt;
    logic [WCW-1:0] win_cnt;
    logic [PCW-1:0] prog_cnt;
    logic           accept_q;
    logic           win_hit;
    logic           prog_hit;

    assign win_hit  = (win_cnt == WIN_LAST);
    assign prog_hit = (prog_cnt == PROG_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (wr_start) nxt = ST_LOAD;
            ST_LOAD: begin
                if (wr_start && page_match) nxt = ST_LOAD;
                else if (win_hit && !wr_active) nxt = ST_PROG;
            end
            ST_PROG: if (prog_hit) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_first = wr_start && (state == ST_IDLE);
        take_load  = wr_start && ((state == ST_IDLE) ||
                                  ((state == ST_LOAD) && page_match));
        capture    = wr_end && accept_q && !wr_inhibit;
        commit     = (state == ST_PROG) && prog_hit;
        busy       = (state == ST_PROG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            win_cnt  <= '0;
            prog_cnt <= '0;
            toggle   <= 1'b0;
        end else begin
            if (wr_start)    accept_q <= take_load;
            else if (wr_end) accept_q <= 1'b0;

            if (take_load) win_cnt <= '0;
            else if ((state == ST_LOAD) && !win_hit) win_cnt <= win_cnt + 1'b1;

            if (state != ST_PROG) prog_cnt <= '0;
            else if (!prog_hit)   prog_cnt <= prog_cnt + 1'b1;

            if (state != ST_PROG)  toggle <= 1'b0;
            else if (prog_hit)     toggle <= 1'b0;
            else if (rd_end)       toggle <= ~toggle;
        end
    end

    // checker counter for the busy-length bound
    logic [BCW-1:0] busy_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_len <= '0;
        else if (state != ST_PROG) busy_len <= '0;
        else if (busy_len != BUSY_CAP) busy_len <= busy_len + 1'b1;
    end

    assert_busy_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= BCW'(PROG_MAX_CYC));

    assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && wr_start) |=> !accept_q);

    assert_prog_via_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_PROG));

    assert_toggle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PROG) |-> (toggle == 1'b0));
endmodule

// File: rtl/pwe_page_buf.sv
module pwe_page_buf #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [DATA_W-1:0]                    dq_in,
    input  logic                                 take_first,
    input  logic                                 take_load,
    input  logic                                 capture,
    input  logic                                 commit,
    input  logic                                 loading,
    input  logic                                 wr_start,
    output logic                                 page_match,
    output logic [ADDR_W-PAGE_BITS-1:0]          page_tag,
    output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] lat_data,
    output logic [(1<<PAGE_BITS)-1:0]            lat_valid,
    output logic [DATA_W-1:0]                    last_byte
);
    localparam int TAG_W     = ADDR_W - PAGE_BITS;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [PAGE_BITS-1:0] off_q;

    assign page_match = (addr[ADDR_W-1:PAGE_BITS] == page_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_tag  <= '0;
            off_q     <= '0;
            last_byte <= '0;
        end else begin
            if (take_first) page_tag <= addr[ADDR_W-1:PAGE_BITS];
            if (take_load)  off_q    <= addr[PAGE_BITS-1:0];
            if (capture)    last_byte <= dq_in;
        end
    end

    for (genvar i = 0; i < PAGE_SIZE; i++) begin : g_slot
        localparam logic [PAGE_BITS-1:0] SLOT = PAGE_BITS'(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lat_data[i]  <= '0;
                lat_valid[i] <= 1'b0;
            end else if (capture && off_q == SLOT) begin
                lat_data[i]  <= dq_in;
                lat_valid[i] <= 1'b1;
            end else if (commit) begin
                lat_valid[i] <= 1'b0;
            end
        end
    end

    assert_offpage_tag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && wr_start && !page_match) |=> $stable(page_tag));

    initial begin
        assert_geom: assert (TAG_W > 0);
    end
endmodule

// File: rtl/pwe_store.sv
module pwe_store #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    rd_addr,
    input  logic                                 commit,
    input  logic [ADDR_W-PAGE_BITS-1:0]          page_tag,
    input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] lat_data,
    input  logic [(1<<PAGE_BITS)-1:0]            lat_valid,
    output logic [DATA_W-1:0]                    rd_data
);
    localparam int TAG_W     = ADDR_W - PAGE_BITS;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam int DEPTH     = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] words;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam int               OFF = w % PAGE_SIZE;
        localparam logic [TAG_W-1:0] PG  = TAG_W'(w / PAGE_SIZE);
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '1;
            else if (commit && page_tag == PG && lat_valid[OFF]) word_q <= lat_data[OFF];
        end
        assign words[w] = word_q;
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/pwe_engine.sv
module pwe_engine
    import pwe_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int PAGE_BITS    = 7,
    parameter int WIN_CYC      = 10000,
    parameter int PROG_CYC     = 300000,
    parameter int PROG_MAX_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wr_inhibit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int TAG_W     = ADDR_W - PAGE_BITS;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic wr_active, wr_start, wr_end, rd_active, rd_end;
    logic take_first, take_load, capture, commit, busy, toggle, page_match;
    pwe_state_e state;
    logic [TAG_W-1:0]                 page_tag;
    logic [PAGE_SIZE-1:0][DATA_W-1:0] lat_data;
    logic [PAGE_SIZE-1:0]             lat_valid;
    logic [DATA_W-1:0]                last_byte;
    logic [DATA_W-1:0]                rd_data;
    logic [DATA_W-1:0]                status;

    pwe_strobe_decode u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_inhibit(wr_inhibit), .wr_active(wr_active), .wr_start(wr_start),
        .wr_end(wr_end), .rd_active(rd_active), .rd_end(rd_end)
    );

    pwe_ctrl #(
        .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC), .PROG_MAX_CYC(PROG_MAX_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
        .wr_active(wr_active), .rd_end(rd_end), .page_match(page_match),
        .wr_inhibit(wr_inhibit), .state(state), .take_first(take_first),
        .take_load(take_load), .capture(capture), .commit(commit),
        .busy(busy), .toggle(toggle)
    );

    pwe_page_buf #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
    ) u_page (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in),
        .take_first(take_first), .take_load(take_load), .capture(capture),
        .commit(commit), .loading(state == ST_LOAD), .wr_start(wr_start),
        .page_match(page_match), .page_tag(page_tag), .lat_data(lat_data),
        .lat_valid(lat_valid), .last_byte(last_byte)
    );

    pwe_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .commit(commit),
        .page_tag(page_tag), .lat_data(lat_data), .lat_valid(lat_valid),
        .rd_data(rd_data)
    );

    assign status = {~last_byte[DATA_W-1], toggle, last_byte[DATA_W-3:0]};
    assign dq_oe  = rd_active;
    assign dq_out = busy ? status : rd_data;
endmodule

// File: tb/pwe_engine_tb.sv
module pwe_engine_tb;
    localparam int AW = 11, DW = 8, PB = 7, WIN = 20, PRG = 40, PMAX = 60;
    localparam int PS = 1 << PB, DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, ce_n, oe_n, we_n, inh;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    pwe_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .WIN_CYC(WIN),
                 .PROG_CYC(PRG), .PROG_MAX_CYC(PMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_inhibit(inh), .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe));

    // behavioural reference model
    int mst, wcnt, bleft, tag, off;
    bit tog, wrq, rdq, acc;
    logic [DW-1:0] lat [PS];
    bit val [PS];
    logic [DW-1:0] last;
    logic [DW-1:0] mm [DEPTH];
    string req = "R11";
    int n_cmp = 0, n_bad = 0;

    task automatic model_step();
        bit wn = !ce_n && !we_n && oe_n && !inh;
        bit rn = !ce_n && !oe_n;
        bit st = wn && !wrq;
        bit en = wrq && !wn;
        bit rend = rdq && !rn;
        int pg = int'(addr) / PS;
        if (en && acc && !inh) begin lat[off] = din; val[off] = 1; last = din; end
        if (en) acc = 0;
        case (mst)
            0: if (st) begin acc = 1; tag = pg; off = int'(addr) % PS; wcnt = 0; mst = 1; end
            1: if (st && pg == tag) begin
                   acc = 1; off = int'(addr) % PS; wcnt = 0;
               end else begin
                   if (st) acc = 0;
                   if (wcnt == WIN - 1 && !wn) begin mst = 2; bleft = PRG; tog = 0; end
                   else if (wcnt < WIN - 1) wcnt++;
               end
            default: begin
                if (st) acc = 0;
                bleft--;
                if (bleft == 0) begin
                    for (int i = 0; i < PS; i++)
                        if (val[i]) begin mm[tag * PS + i] = lat[i]; val[i] = 0; end
                    tog = 0; mst = 0;
                end else if (rend) tog = !tog;
            end
        endcase
        wrq = wn; rdq = rn;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; wcnt = 0; bleft = 0; tag = 0; off = 0; tog = 0; wrq = 0;
            rdq = 0; acc = 0; last = '0;
            for (int i = 0; i < PS; i++) begin lat[i] = '0; val[i] = 0; end
            for (int i = 0; i < DEPTH; i++) mm[i] = 8'hFF;
        end else model_step();
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_oe;
            logic [DW-1:0] exp_d;
            exp_oe = !ce_n && !oe_n;
            n_cmp++;
            if (dq_oe !== exp_oe) begin
                n_bad++;
                $display("FAIL %s: dq_oe got %0b exp %0b at %0t", req, dq_oe, exp_oe, $time);
            end
            if (exp_oe) begin
                exp_d = (mst == 2) ? {~last[7], tog, last[5:0]} : mm[addr];
                n_cmp++;
                if (dq_out !== exp_d) begin
                    n_bad++;
                    $display("FAIL %s: dq_out got %h exp %h at %0t", req, dq_out, exp_d, $time);
                end
            end
        end
    end

    task automatic step(input logic c, input logic o, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #2;
        ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
    endtask

    task automatic idle(input int n);
        repeat (n) step(1, 1, 1, addr, din);
    endtask

    task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(0, 1, 1, a, d); step(0, 1, 0, a, d); step(0, 1, 0, a, d);
        step(0, 1, 1, a, d); step(1, 1, 1, a, d);
    endtask

    task automatic wr_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(1, 1, 0, a, d); step(0, 1, 0, a, d); step(0, 1, 0, a, d);
        step(1, 1, 0, a, d); step(1, 1, 1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        step(0, 0, 1, a, din); step(1, 1, 1, a, din);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got hang exp finish");
        finish_run();
    end

    initial begin
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; inh = 0; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        req = "R11"; rd(0); rd(11'd2047); rd(11'd300);

        req = "R1"; step(0, 1, 1, 5, 0); step(1, 0, 1, 5, 0); step(0, 0, 1, 5, 0); idle(2);

        // R2: address from start edge, data from end edge, both strobe orders
        req = "R2";
        step(0, 1, 1, 130, 8'h11); step(0, 1, 0, 130, 8'h11);
        step(0, 1, 0, 131, 8'h22); step(0, 1, 1, 131, 8'h5A); step(1, 1, 1, 131, 8'h5A);
        wr_ce(135, 8'h3C);
        // R4: hold a read across the window lapse
        req = "R4";
        repeat (WIN + 4) step(0, 0, 1, 130, din);
        idle(1);
        req = "R6 R7";
        repeat (8) rd(130);
        idle(PRG);
        req = "R8"; rd(130); rd(131); rd(135);

        // R5: many renewals spanning far more than one window
        req = "R5";
        for (int k = 0; k < 12; k++) begin
            wr_we(AW'(384 + 3 * k), DW'(8'h40 + k));
            idle(10);
            rd(AW'(384 + 3 * k));
        end
        idle(WIN + PRG + 5);
        for (int k = 0; k < 12; k++) rd(AW'(384 + 3 * k));

        // R3: off-page load discarded, window not re-opened
        req = "R3";
        wr_we(512, 8'h44); idle(4); wr_we(700, 8'h99);
        repeat (WIN) step(0, 0, 1, 512, din);
        idle(WIN + PRG);
        rd(512); rd(700);

        // R9: loads during programming are ignored
        req = "R9";
        wr_we(768, 8'h66); idle(WIN + 3);
        wr_we(769, 8'h77); wr_ce(900, 8'h12); rd(768);
        idle(PRG + WIN);
        rd(768); rd(769); rd(900);

        // R10: inhibit and output-enable-low block loads
        req = "R10";
        inh = 1; wr_we(1000, 8'h10); inh = 0;
        step(0, 0, 0, 1001, 8'h20); step(0, 0, 0, 1001, 8'h20); step(1, 1, 1, 1001, 8'h20);
        repeat (WIN + 5) step(0, 0, 1, 1000, din);
        rd(1000); rd(1001);
        idle(3);
        finish_run();
    end
endmodule